// File: doc/BRIEF.md
# Trigger Qualifier with Lost-Trigger Accounting

This block stands between a trigger source and an acquisition engine. Each incoming trigger pulse is either passed on as a one-cycle start pulse or refused. A trigger is refused when a capture is still running, when it follows the last accepted trigger too closely, when the frame buffer reports no free room, or when any power-monitor line signals a fault. A global enable gates all of this: while it is low, triggers are dropped silently.

A refused trigger raises a lost-trigger count and sets one sticky reason bit for each condition that blocked it. When the running capture ends, the count and the reason bits are copied into header outputs and cleared in the same cycle. The header builder uses these values together with a timestamp, the general-purpose input state latched at the accepted trigger, and a wrapping frame number.

Top module: `trig_qualifier`

## Requirements
- R1: An enabled trigger with no blocking condition gives `start_pulse` high for one cycle after the sampling edge. In that same cycle `cap_stamp` and `cap_gpi` hold the `timer_val` and `gpi` values seen at that edge.
- R2: A trigger that arrives between an accepted start and the matching `acq_done` is refused and sets reason bit 0 (busy).
- R3: A trigger sampled fewer than `HOLDOFF_CYC` cycles after the edge of the last accepted trigger is refused and sets reason bit 1 (hold-off). A trigger exactly `HOLDOFF_CYC` cycles later is accepted. Refused triggers do not restart the hold-off.
- R4: A trigger sampled while `buf_full` is high is refused and sets reason bit 2 (no room).
- R5: A trigger sampled while any bit of `pwr_fault` is high is refused and sets reason bit 3 (power).
- R6: A single refused trigger sets every reason bit whose condition holds at that edge. The reason bits are sticky until the next snapshot.
- R7: Each refused trigger adds one to the lost-trigger count. The count saturates at its all-ones value.
- R8: `acq_done` during a capture ends the capture. One cycle later `hdr_strobe` pulses and `hdr_lost` and `hdr_flags` show the count and reason bits gathered up to that edge, and the internal counters are cleared. A trigger refused at that same edge is the first entry of the next interval.
- R9: `frame_idx` increases by one on each accepted trigger. The first one gives 1, and it wraps from all-ones to 0.
- R10: A trigger while `trig_en` is low gives no start and changes neither the count nor the reason bits.
- R11: `acq_done` while no capture is running gives no `hdr_strobe` and leaves the header outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_en | input | 1 | Global trigger enable |
| trig_in | input | 1 | Trigger pulse, one per cycle high |
| acq_done | input | 1 | End-of-capture pulse |
| buf_full | input | 1 | Buffer has no room for a frame |
| pwr_fault | input | PWR_W | Power-monitor fault lines |
| timer_val | input | TS_W | Free-running timer value |
| gpi | input | GPI_W | General-purpose input pins |
| start_pulse | output | 1 | Accepted-start pulse |
| cap_stamp | output | TS_W | Timer value latched at accept |
| cap_gpi | output | GPI_W | Input-pin state latched at accept |
| frame_idx | output | IDX_W | Frame number of the latest accept |
| hdr_strobe | output | 1 | Header snapshot valid pulse |
| hdr_lost | output | LOST_W | Lost-trigger count of the interval |
| hdr_flags | output | 4 | Reason bits of the interval |

## Verification
A table drives single triggers under enable, buffer-full and power-fault patterns, taken alone and in combination. It shows whether each reason maps to its own bit and whether disabled triggers stay uncounted. Directed sequences then fire triggers back to back and just inside and just at the hold-off limit. These separate busy from hold-off refusals and find off-by-one errors in the window. Further sequences put a trigger in the same edge as the end-of-capture pulse, push the count past its saturation point, send an end pulse while idle, and run enough captures to wrap the frame number.

// File: rtl/trig_qualifier.sv
module trig_qualifier #(
  parameter int HOLDOFF_CYC = 10000,
  parameter int TS_W        = 32,
  parameter int GPI_W       = 6,
  parameter int IDX_W       = 16,
  parameter int LOST_W      = 16,
  parameter int PWR_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_en,
  input  logic              trig_in,
  input  logic              acq_done,
  input  logic              buf_full,
  input  logic [PWR_W-1:0]  pwr_fault,
  input  logic [TS_W-1:0]   timer_val,
  input  logic [GPI_W-1:0]  gpi,
  output logic              start_pulse,
  output logic [TS_W-1:0]   cap_stamp,
  output logic [GPI_W-1:0]  cap_gpi,
  output logic [IDX_W-1:0]  frame_idx,
  output logic              hdr_strobe,
  output logic [LOST_W-1:0] hdr_lost,
  output logic [3:0]        hdr_flags
);
  localparam int HO_W = $clog2(HOLDOFF_CYC + 1);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;
  localparam logic [HO_W-1:0] HO_LOAD = HO_W'(HOLDOFF_CYC - 1);

  logic              busy;
  logic [HO_W-1:0]   ho_cnt;
  logic [LOST_W-1:0] lost_cnt;
  logic [3:0]        flags;

  // reason bits: 3 power, 2 no room, 1 hold-off, 0 busy
  wire [3:0] why    = {|pwr_fault, buf_full, ho_cnt != '0, busy};
  wire       armed  = trig_in & trig_en;
  wire       accept = armed & (why == 4'b0);
  wire       refuse = armed & (why != 4'b0);
  wire       close  = acq_done & busy;
  wire [LOST_W-1:0] lost_inc = (lost_cnt == LOST_MAX) ? lost_cnt : lost_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      ho_cnt      <= '0;
      lost_cnt    <= '0;
      flags       <= '0;
      start_pulse <= 1'b0;
      cap_stamp   <= '0;
      cap_gpi     <= '0;
      frame_idx   <= '0;
      hdr_strobe  <= 1'b0;
      hdr_lost    <= '0;
      hdr_flags   <= '0;
    end else begin
      start_pulse <= accept;
      hdr_strobe  <= close;

      if (accept)     busy <= 1'b1;
      else if (close) busy <= 1'b0;

      if (accept)              ho_cnt <= HO_LOAD;
      else if (ho_cnt != '0)   ho_cnt <= ho_cnt - 1'b1;

      if (accept) begin
        cap_stamp <= timer_val;
        cap_gpi   <= gpi;
        frame_idx <= frame_idx + 1'b1;
      end

      if (close) begin
        hdr_lost  <= lost_cnt;
        hdr_flags <= flags;
        lost_cnt  <= refuse ? LOST_W'(1) : '0;
        flags     <= refuse ? why : 4'b0;
      end else if (refuse) begin
        lost_cnt <= lost_inc;
        flags    <= flags | why;
      end
    end
  end

  // independent spacing counter used by the hold-off check
  logic [HO_W-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                       gap_cnt <= HO_W'(HOLDOFF_CYC);
    else if (start_pulse)             gap_cnt <= HO_W'(1);
    else if (gap_cnt < HO_W'(HOLDOFF_CYC)) gap_cnt <= gap_cnt + 1'b1;
  end

  assert_start_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(trig_en && trig_in));

  assert_no_start_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(busy));

  assert_no_start_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(buf_full));

  assert_no_start_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(pwr_fault) == '0);

  assert_holdoff_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> gap_cnt >= HO_W'(HOLDOFF_CYC));

  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> frame_idx == IDX_W'($past(frame_idx) + 1'b1));

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |-> $stable(frame_idx));

  assert_lost_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_strobe && $past(lost_cnt) == LOST_MAX) |-> lost_cnt == LOST_MAX);

  assert_snapshot_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |-> hdr_lost == $past(lost_cnt));

  assert_header_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_strobe |-> ($stable(hdr_lost) && $stable(hdr_flags)));
endmodule

// File: tb/trig_qualifier_test.sv
module trig_qualifier_test;
  localparam int HO = 16, TS_W = 32, GPI_W = 6, IDX_W = 4, LOST_W = 4, PWR_W = 3;

  logic clk = 0, rst_n = 0, trig_en = 0, trig_in = 0, acq_done = 0, buf_full = 0;
  logic [PWR_W-1:0] pwr_fault = '0;
  logic [TS_W-1:0]  timer_val = '0;
  logic [GPI_W-1:0] gpi = '0;
  logic start_pulse, hdr_strobe;
  logic [TS_W-1:0] cap_stamp;
  logic [GPI_W-1:0] cap_gpi;
  logic [IDX_W-1:0] frame_idx;
  logic [LOST_W-1:0] hdr_lost;
  logic [3:0] hdr_flags;

  trig_qualifier #(.HOLDOFF_CYC(HO), .TS_W(TS_W), .GPI_W(GPI_W), .IDX_W(IDX_W),
                   .LOST_W(LOST_W), .PWR_W(PWR_W)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [IDX_W-1:0] exp_idx = '0;

  // {en, full, pwr[2:0], exp_start, exp_lost[3:0], exp_flags[3:0]}
  localparam logic [13:0] VEC [0:5] = '{
    14'b1_0_000_1_0000_0000,
    14'b1_1_000_0_0001_0100,
    14'b1_0_010_0_0001_1000,
    14'b1_1_100_0_0001_1100,
    14'b0_1_000_0_0000_0000,
    14'b0_0_000_0_0000_0000
  };
  string vreq [0:5] = '{"R1", "R4", "R5", "R6", "R10", "R10"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire();
    trig_in = 1; @(negedge clk); trig_in = 0;
  endtask

  task automatic finish_acq();
    acq_done = 1; @(negedge clk); acq_done = 0;
  endtask

  task automatic fire_ok(input logic [31:0] ts, input logic [GPI_W-1:0] g);
    timer_val = ts; gpi = g;
    fire();
    exp_idx = exp_idx + 1'b1;
    chk("R1 start", start_pulse, 1);
    chk("R1 stamp", cap_stamp, ts);
    chk("R1 gpi", cap_gpi, g);
    chk("R9 index", frame_idx, exp_idx);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset start", start_pulse, 0);
    chk("R9 reset index", frame_idx, 0);
    chk("R8 reset lost", hdr_lost, 0);
    chk("R8 reset flags", hdr_flags, 0);
    chk("R8 reset strobe", hdr_strobe, 0);

    // table walk: single trigger under each condition pattern
    for (int i = 0; i < 6; i++) begin
      logic [13:0] v;
      v = VEC[i];
      trig_en = v[13]; buf_full = v[12]; pwr_fault = v[11:9];
      timer_val = 32'h1000 + i;
      fire();
      chk(vreq[i], start_pulse, v[8]);
      trig_en = 1; buf_full = 0; pwr_fault = '0;
      if (v[8]) begin
        exp_idx = exp_idx + 1'b1;
        chk("R9 index", frame_idx, exp_idx);
      end else begin
        idle(HO);
        fire_ok(32'h2000 + i, 6'(i));
      end
      finish_acq();
      chk("R8 strobe", hdr_strobe, 1);
      chk(vreq[i], hdr_lost, v[7:4]);
      chk(vreq[i], hdr_flags, v[3:0]);
      idle(HO + 2);
    end

    // R2 and R6: busy plus hold-off, then busy alone
    fire_ok(32'h3000, 6'h15);
    fire();
    chk("R6 busy+holdoff", start_pulse, 0);
    idle(HO);
    fire();
    chk("R2 busy", start_pulse, 0);
    chk("R1 stamp kept", cap_stamp, 32'h3000);
    finish_acq();
    chk("R6 lost", hdr_lost, 2);
    chk("R6 flags", hdr_flags, 4'b0011);
    idle(HO + 2);

    // R8: trigger refused at the end edge counts toward next interval
    fire_ok(32'h4000, 6'h2a);
    idle(HO + 2);
    acq_done = 1; trig_in = 1;
    @(negedge clk);
    acq_done = 0; trig_in = 0;
    chk("R8 strobe", hdr_strobe, 1);
    chk("R8 lost old", hdr_lost, 0);
    chk("R8 flags old", hdr_flags, 0);
    chk("R2 start", start_pulse, 0);
    fire_ok(32'h4100, 6'h01);
    finish_acq();
    chk("R8 lost carried", hdr_lost, 1);
    chk("R2 flag carried", hdr_flags, 4'b0001);
    idle(HO + 2);

    // R3: boundary of the hold-off window
    fire_ok(32'h5000, 6'h03);
    finish_acq();
    idle(HO - 3);
    fire();
    chk("R3 inside window", start_pulse, 0);
    fire_ok(32'h5100, 6'h04);
    finish_acq();
    chk("R3 lost", hdr_lost, 1);
    chk("R3 flags", hdr_flags, 4'b0010);
    idle(HO + 2);

    // R7: saturation of the lost count
    fire_ok(32'h6000, 6'h05);
    for (int k = 0; k < 20; k++) fire();
    finish_acq();
    chk("R7 saturated", hdr_lost, 15);
    chk("R7 flags", hdr_flags, 4'b0011);
    idle(HO + 2);

    // R11: end pulse while idle
    finish_acq();
    chk("R11 strobe", hdr_strobe, 0);
    chk("R11 lost kept", hdr_lost, 15);
    chk("R11 flags kept", hdr_flags, 4'b0011);

    // R9: frame number wrap
    for (int k = 0; k < 20; k++) begin
      fire_ok(32'h7000 + k, 6'(k));
      if (exp_idx == '0) chk("R9 wrap", frame_idx, 0);
      finish_acq();
      idle(HO);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule